// File: doc/BRIEF.md
# Effective Address Generator

This unit turns the memory-operand description of an instruction into the operand's offset and the segment register it is taken from. The caller presents a ModRM byte together with the address size (16 or 32 bits) and an optional segment override. The unit then pulls any further instruction bytes it needs from a byte stream with valid/ready handshaking, one byte per cycle. In 32-bit size this can be a SIB byte, followed by a displacement of 0, 1, 2 or 4 bytes, least significant byte first. When all bytes are in, the unit adds the selected base register, the scaled index register and the extended displacement. It reports the offset and the segment index with a one-cycle done pulse.

The eight general registers arrive on a flat parallel bus. Register n occupies bits [32n+31:32n], in the order EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI. In 16-bit size the low halves act as the BX, BP, SI and DI views. The register bus must stay stable from the acceptance of a ModRM byte until its done pulse. Segment indices are ES=0, CS=1, SS=2, DS=3, FS=4 and GS=5. The value 7 on the override input means that no override is present. Register-operand forms (mod=11) are rejected with an error flag.

Top module: `eff_addr_unit`

## Requirements
- R1: After reset, done, err and byte_ready are 0 and start_ready is 1.
- R2: In 16-bit size, r/m values 0 to 7 add BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX to the displacement. The result keeps only its low 16 bits, and r/m=100 does not fetch a SIB byte.
- R3: In 16-bit size, mod=00 with r/m=110 fetches a two-byte displacement, zero-extended, which alone forms the offset. BP is not added and the default segment is DS.
- R4: mod=01 fetches one byte, sign-extended. mod=10 fetches two bytes, sign-extended, in 16-bit size and four bytes in 32-bit size. Multi-byte displacements arrive least significant byte first, and exactly that many bytes are consumed.
- R5: In 32-bit size without a SIB byte, the offset is the register chosen by r/m plus the displacement, wrapping modulo 2^32.
- R6: In 32-bit size, r/m=100 fetches a SIB byte. Bits 7:6 hold the scale, bits 5:3 the index register and bits 2:0 the base register. The base register stands in for r/m, and the index register, shifted left by the scale, is added to the offset.
- R7: A SIB index field of 100 adds no index term, whatever the scale.
- R8: In 32-bit size, mod=00 with r/m or SIB base equal to 101 fetches a four-byte displacement and adds no base register.
- R9: The default segment is SS (2) for the BP-based 16-bit forms and for the ESP- or EBP-based 32-bit forms, except for the direct forms of R3 and R8. All other forms default to DS (3). An override code other than 7 replaces the default.
- R10: While the unit waits for a byte and byte_valid is low, it holds byte_ready high and makes no progress. start_ready stays low from the acceptance of a ModRM byte through its done cycle.
- R11: mod=11 consumes no stream bytes and ends with done and err both high and an offset of 0.
- R12: done is a single-cycle pulse, and offset, seg_out and err are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | A ModRM byte is presented |
| start_ready | output | 1 | Unit can accept a ModRM byte |
| modrm | input | 8 | ModRM byte |
| addr32 | input | 1 | 1 selects 32-bit address size, 0 selects 16-bit |
| seg_ovr | input | 3 | Segment override index, 7 for none |
| byte_valid | input | 1 | Stream byte is present |
| byte_ready | output | 1 | Unit takes the stream byte this cycle |
| byte_data | input | 8 | Stream byte (SIB or displacement) |
| gpr_flat | input | 256 | Eight 32-bit general registers, EAX in the lowest bits |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Register-operand form rejected (with done) |
| offset | output | 32 | Computed memory offset |
| seg_out | output | 3 | Selected segment register index |

## Verification
On every cycle, the assertions check that done is a single-cycle pulse and that the two ready signals never overlap. They also check that a stalled byte request stays raised, that start_ready drops after a ModRM byte is accepted, that 16-bit results never use the upper half, and that an error result carries a zero offset. The arithmetic itself can only be shown by the bench's directed scenarios. These cover the form tables, the displacement extension and byte order, the SIB scale and the no-index code, the direct forms, the default and override segments, and wraparound. The bench also counts the stream bytes consumed in each case.

// File: rtl/eag_pkg.sv
package eag_pkg;

  typedef enum logic [2:0] {
    DK_NONE = 3'd0,
    DK_S8   = 3'd1,
    DK_S16  = 3'd2,
    DK_Z16  = 3'd3,
    DK_D32  = 3'd4
  } disp_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ROUTE = 3'd1,
    ST_SIB   = 3'd2,
    ST_DISP  = 3'd3,
    ST_CALC  = 3'd4
  } eag_state_t;

  localparam logic [2:0] SEG_ES   = 3'd0;
  localparam logic [2:0] SEG_CS   = 3'd1;
  localparam logic [2:0] SEG_SS   = 3'd2;
  localparam logic [2:0] SEG_DS   = 3'd3;
  localparam logic [2:0] SEG_NONE = 3'd7;

  localparam logic [2:0] GR_AX = 3'd0;
  localparam logic [2:0] GR_CX = 3'd1;
  localparam logic [2:0] GR_DX = 3'd2;
  localparam logic [2:0] GR_BX = 3'd3;
  localparam logic [2:0] GR_SP = 3'd4;
  localparam logic [2:0] GR_BP = 3'd5;
  localparam logic [2:0] GR_SI = 3'd6;
  localparam logic [2:0] GR_DI = 3'd7;

  function automatic logic [2:0] disp_len(disp_kind_t k);
    case (k)
      DK_S8:          disp_len = 3'd1;
      DK_S16, DK_Z16: disp_len = 3'd2;
      DK_D32:         disp_len = 3'd4;
      default:        disp_len = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/eag_form_decode.sv
module eag_form_decode
  import eag_pkg::*;
(
  input  logic       mode32,
  input  logic [1:0] mod_f,
  input  logic [2:0] rm_f,
  input  logic       sib_en,
  input  logic [2:0] sib_index,
  input  logic [1:0] sib_scale,
  output disp_kind_t dkind,
  output logic       base_en,
  output logic [2:0] base_sel,
  output logic       idx_en,
  output logic [2:0] idx_sel,
  output logic [1:0] idx_shift,
  output logic [2:0] dflt_seg
);

  always_comb begin
    dkind     = DK_NONE;
    base_en   = 1'b0;
    base_sel  = GR_AX;
    idx_en    = 1'b0;
    idx_sel   = GR_AX;
    idx_shift = 2'd0;
    dflt_seg  = SEG_DS;
    if (!mode32) begin
      case (mod_f)
        2'd1:    dkind = DK_S8;
        2'd2:    dkind = DK_S16;
        default: dkind = (mod_f == 2'd0 && rm_f == 3'd6) ? DK_Z16 : DK_NONE;
      endcase
      case (rm_f)
        3'd0: begin base_en = 1'b1; base_sel = GR_BX; idx_en = 1'b1; idx_sel = GR_SI; end
        3'd1: begin base_en = 1'b1; base_sel = GR_BX; idx_en = 1'b1; idx_sel = GR_DI; end
        3'd2: begin base_en = 1'b1; base_sel = GR_BP; idx_en = 1'b1; idx_sel = GR_SI; dflt_seg = SEG_SS; end
        3'd3: begin base_en = 1'b1; base_sel = GR_BP; idx_en = 1'b1; idx_sel = GR_DI; dflt_seg = SEG_SS; end
        3'd4: begin base_en = 1'b1; base_sel = GR_SI; end
        3'd5: begin base_en = 1'b1; base_sel = GR_DI; end
        3'd6: begin
          if (mod_f != 2'd0) begin
            base_en  = 1'b1;
            base_sel = GR_BP;
            dflt_seg = SEG_SS;
          end
        end
        default: begin base_en = 1'b1; base_sel = GR_BX; end
      endcase
    end else begin
      case (mod_f)
        2'd1:    dkind = DK_S8;
        2'd2:    dkind = DK_D32;
        default: dkind = (mod_f == 2'd0 && rm_f == 3'd5) ? DK_D32 : DK_NONE;
      endcase
      if (!(mod_f == 2'd0 && rm_f == 3'd5)) begin
        base_en  = 1'b1;
        base_sel = rm_f;
        if (rm_f == GR_SP || rm_f == GR_BP) dflt_seg = SEG_SS;
      end
      if (sib_en && sib_index != GR_SP) begin
        idx_en    = 1'b1;
        idx_sel   = sib_index;
        idx_shift = sib_scale;
      end
    end
  end

endmodule

// File: rtl/eag_disp_collect.sv
module eag_disp_collect
  import eag_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  localparam int DISP_W   = BYTE_W * MAX_BYTES,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [BYTE_W-1:0] byte_in,
  input  disp_kind_t        dkind,
  output logic [CNT_W-1:0]  count,
  output logic [DISP_W-1:0] disp_ext
);

  logic [BYTE_W-1:0] lane [MAX_BYTES];
  logic [DISP_W-1:0] raw;

  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (load)    count <= count + 1'b1;
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear)                     lane[g] <= '0;
      else if (load && count == CNT_W'(g))  lane[g] <= byte_in;
    end
    assign raw[g*BYTE_W +: BYTE_W] = lane[g];
  end

  always_comb begin
    case (dkind)
      DK_S8:   disp_ext = {{(DISP_W-BYTE_W){raw[BYTE_W-1]}}, raw[BYTE_W-1:0]};
      DK_S16:  disp_ext = {{(DISP_W-2*BYTE_W){raw[2*BYTE_W-1]}}, raw[2*BYTE_W-1:0]};
      DK_Z16:  disp_ext = {{(DISP_W-2*BYTE_W){1'b0}}, raw[2*BYTE_W-1:0]};
      DK_D32:  disp_ext = raw;
      default: disp_ext = '0;
    endcase
  end

endmodule

// File: rtl/eag_offset_sum.sv
module eag_offset_sum #(
  parameter int REG_W  = 32,
  parameter int NREG   = 8,
  localparam int SEL_W = $clog2(NREG),
  localparam int HALF_W = REG_W / 2
) (
  input  logic [NREG*REG_W-1:0] gpr_flat,
  input  logic                  mode32,
  input  logic                  base_en,
  input  logic [SEL_W-1:0]      base_sel,
  input  logic                  idx_en,
  input  logic [SEL_W-1:0]      idx_sel,
  input  logic [1:0]            idx_shift,
  input  logic [REG_W-1:0]      disp,
  output logic [REG_W-1:0]      sum
);

  logic [REG_W-1:0] gpr [NREG];
  logic [REG_W-1:0] base_term;
  logic [REG_W-1:0] idx_term;
  logic [REG_W-1:0] full;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign gpr[g] = gpr_flat[g*REG_W +: REG_W];
  end

  always_comb begin
    base_term = base_en ? gpr[base_sel] : '0;
    idx_term  = idx_en ? (gpr[idx_sel] << idx_shift) : '0;
    full      = base_term + idx_term + disp;
    sum       = mode32 ? full : {{(REG_W-HALF_W){1'b0}}, full[HALF_W-1:0]};
  end

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eag_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int NREG   = 8,
  parameter int BYTE_W = 8,
  localparam int MAX_BYTES = REG_W / BYTE_W,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  output logic                  start_ready,
  input  logic [7:0]            modrm,
  input  logic                  addr32,
  input  logic [2:0]            seg_ovr,
  input  logic                  byte_valid,
  output logic                  byte_ready,
  input  logic [BYTE_W-1:0]     byte_data,
  input  logic [NREG*REG_W-1:0] gpr_flat,
  output logic                  done,
  output logic                  err,
  output logic [REG_W-1:0]      offset,
  output logic [2:0]            seg_out
);

  eag_state_t  state;
  logic [1:0]  mod_q;
  logic [2:0]  rm_q;
  logic        mode32_q;
  logic [2:0]  ovr_q;
  logic [7:0]  sib_q;
  logic        sib_seen_q;

  logic [2:0]  rm_eff;
  disp_kind_t  dkind;
  logic        base_en, idx_en;
  logic [2:0]  base_sel, idx_sel, dflt_seg;
  logic [1:0]  idx_shift;
  logic [CNT_W-1:0]  dcount;
  logic [REG_W-1:0]  disp_ext;
  logic [REG_W-1:0]  sum;
  logic [2:0]        nbytes;
  logic              take_start, take_byte, load_disp;

  assign start_ready = (state == ST_IDLE) && !done;
  assign byte_ready  = (state == ST_SIB) || (state == ST_DISP);
  assign take_start  = start && start_ready;
  assign take_byte   = byte_ready && byte_valid;
  assign load_disp   = take_byte && (state == ST_DISP);
  assign rm_eff      = sib_seen_q ? sib_q[2:0] : rm_q;
  assign nbytes      = disp_len(dkind);

  eag_form_decode u_dec (
    .mode32    (mode32_q),
    .mod_f     (mod_q),
    .rm_f      (rm_eff),
    .sib_en    (sib_seen_q),
    .sib_index (sib_q[5:3]),
    .sib_scale (sib_q[7:6]),
    .dkind     (dkind),
    .base_en   (base_en),
    .base_sel  (base_sel),
    .idx_en    (idx_en),
    .idx_sel   (idx_sel),
    .idx_shift (idx_shift),
    .dflt_seg  (dflt_seg)
  );

  eag_disp_collect #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES)) u_disp (
    .clk      (clk),
    .rst      (rst),
    .clear    (take_start),
    .load     (load_disp),
    .byte_in  (byte_data),
    .dkind    (dkind),
    .count    (dcount),
    .disp_ext (disp_ext)
  );

  eag_offset_sum #(.REG_W(REG_W), .NREG(NREG)) u_sum (
    .gpr_flat  (gpr_flat),
    .mode32    (mode32_q),
    .base_en   (base_en),
    .base_sel  (base_sel),
    .idx_en    (idx_en),
    .idx_sel   (idx_sel),
    .idx_shift (idx_shift),
    .disp      (disp_ext),
    .sum       (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mod_q      <= '0;
      rm_q       <= '0;
      mode32_q   <= 1'b0;
      ovr_q      <= SEG_NONE;
      sib_q      <= '0;
      sib_seen_q <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      offset     <= '0;
      seg_out    <= SEG_DS;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take_start) begin
            mod_q      <= modrm[7:6];
            rm_q       <= modrm[2:0];
            mode32_q   <= addr32;
            ovr_q      <= seg_ovr;
            sib_q      <= '0;
            sib_seen_q <= 1'b0;
            state      <= ST_ROUTE;
          end
        end
        ST_ROUTE: begin
          if (mod_q == 2'd3) begin
            done   <= 1'b1;
            err    <= 1'b1;
            offset <= '0;
            state  <= ST_IDLE;
          end else if (mode32_q && rm_q == 3'd4 && !sib_seen_q) begin
            state <= ST_SIB;
          end else if (nbytes != 3'd0) begin
            state <= ST_DISP;
          end else begin
            state <= ST_CALC;
          end
        end
        ST_SIB: begin
          if (take_byte) begin
            sib_q      <= byte_data;
            sib_seen_q <= 1'b1;
            state      <= ST_ROUTE;
          end
        end
        ST_DISP: begin
          if (take_byte && dcount == CNT_W'(nbytes - 3'd1)) state <= ST_CALC;
        end
        ST_CALC: begin
          done    <= 1'b1;
          err     <= 1'b0;
          offset  <= sum;
          seg_out <= (ovr_q == SEG_NONE) ? dflt_seg : ovr_q;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eag_checker.sv
module eag_checker #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             start_ready,
  input logic             byte_valid,
  input logic             byte_ready,
  input logic             done,
  input logic             err,
  input logic [REG_W-1:0] offset,
  input logic [2:0]       seg_out,
  input logic             mode32_q
);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_ready_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(start_ready && byte_ready));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (byte_ready && !byte_valid) |=> byte_ready);

  p_busy_after_start_r10: assert property (@(posedge clk) disable iff (rst)
    (start && start_ready) |=> !start_ready);

  p_err_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (offset == '0));

  p_short_offset_r2: assert property (@(posedge clk) disable iff (rst)
    (done && !err && !mode32_q) |-> (offset[REG_W-1:REG_W/2] == '0));

  p_seg_code_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (seg_out != 3'd6 && seg_out != 3'd7));

endmodule

bind eff_addr_unit eag_checker #(.REG_W(REG_W)) u_eag_checker (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .start_ready (start_ready),
  .byte_valid  (byte_valid),
  .byte_ready  (byte_ready),
  .done        (done),
  .err         (err),
  .offset      (offset),
  .seg_out     (seg_out),
  .mode32_q    (mode32_q)
);

// File: tb/test_eff_addr_unit.sv
`timescale 1ns/1ps
module test_eff_addr_unit;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         start_ready;
  logic [7:0]   modrm = '0;
  logic         addr32 = 1'b0;
  logic [2:0]   seg_ovr = 3'd7;
  logic         byte_valid = 1'b0;
  logic         byte_ready;
  logic [7:0]   byte_data = '0;
  logic [255:0] gpr_flat;
  logic         done, err;
  logic [31:0]  offset;
  logic [2:0]   seg_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  localparam logic [31:0] V_EAX = 32'h1000_0010;
  localparam logic [31:0] V_ECX = 32'h0000_0200;
  localparam logic [31:0] V_EDX = 32'hFFFF_FFF0;
  localparam logic [31:0] V_EBX = 32'h0000_1234;
  localparam logic [31:0] V_ESP = 32'h0000_8000;
  localparam logic [31:0] V_EBP = 32'h0000_4000;
  localparam logic [31:0] V_ESI = 32'h0000_0056;
  localparam logic [31:0] V_EDI = 32'h0000_F00F;

  assign gpr_flat = {V_EDI, V_ESI, V_EBP, V_ESP, V_EBX, V_EDX, V_ECX, V_EAX};

  always #2.5 clk = ~clk;

  eff_addr_unit i_eff_addr_unit (
    .clk(clk), .rst(rst), .start(start), .start_ready(start_ready),
    .modrm(modrm), .addr32(addr32), .seg_ovr(seg_ovr),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .gpr_flat(gpr_flat), .done(done), .err(err), .offset(offset), .seg_out(seg_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_ea(input string req, input logic [7:0] m, input logic a32,
                        input logic [2:0] ovr, input logic [39:0] bytes, input int n,
                        input int gap, input logic [31:0] exp_off,
                        input logic [2:0] exp_seg, input logic exp_err);
    int idx = 0;
    int held = 0;
    int cyc = 0;
    bit busy_bad = 0;
    bit stall_bad = 0;
    bit stalled = 0;
    @(negedge clk);
    chk(start_ready == 1'b1, {req, " start_ready idle"}, 32'(start_ready), 32'd1);
    start = 1'b1; modrm = m; addr32 = a32; seg_ovr = ovr;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 200) begin
      if (stalled && (!byte_ready || done)) stall_bad = 1;
      stalled = 0;
      if (start_ready) busy_bad = 1;
      if (byte_ready && idx < n) begin
        if (held < gap) begin
          byte_valid = 1'b0; held++; stalled = 1;
        end else begin
          byte_valid = 1'b1; byte_data = bytes[8*idx +: 8]; idx++; held = 0;
        end
      end else begin
        byte_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    byte_valid = 1'b0;
    chk(done == 1'b1, {req, " done seen"}, 32'(done), 32'd1);
    chk(err == exp_err, {req, " err"}, 32'(err), 32'(exp_err));
    chk(offset == exp_off, {req, " offset"}, offset, exp_off);
    if (!exp_err) chk(seg_out == exp_seg, {req, " segment"}, 32'(seg_out), 32'(exp_seg));
    chk(idx == n, {req, " bytes consumed"}, 32'(idx), 32'(n));
    chk(!busy_bad, "R10 start_ready low while busy", 32'(busy_bad), 32'd0);
    if (gap > 0) chk(!stall_bad, "R10 stall holds", 32'(stall_bad), 32'd0);
    @(negedge clk);
    chk(done == 1'b0, "R12 done single pulse", 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk(done == 1'b0 && err == 1'b0, "R1 reset done/err", {30'd0, done, err}, 32'd0);
    chk(start_ready == 1'b1 && byte_ready == 1'b0, "R1 reset readies",
        {30'd0, start_ready, byte_ready}, 32'd2);
  endtask

  task automatic t_16bit;
    run_ea("R2 bx+si", 8'h00, 1'b0, 3'd7, 40'h0, 0, 0, (V_EBX + V_ESI) & 32'hFFFF, 3'd3, 1'b0);
    run_ea("R2 R4 bp+si+d8 neg", 8'h42, 1'b0, 3'd7, 40'hF0, 1, 0,
           (V_EBP + V_ESI - 32'd16) & 32'hFFFF, 3'd2, 1'b0);
    run_ea("R4 bx+d16 neg", 8'h87, 1'b0, 3'd7, 40'h8000, 2, 0,
           (V_EBX + 32'hFFFF_8000) & 32'hFFFF, 3'd3, 1'b0);
    run_ea("R9 bp+d8", 8'h46, 1'b0, 3'd7, 40'h05, 1, 0, V_EBP + 32'd5, 3'd2, 1'b0);
    run_ea("R2 wrap bp+di+d16", 8'h83, 1'b0, 3'd7, 40'h1000, 2, 0,
           (V_EBP + V_EDI + 32'h1000) & 32'hFFFF, 3'd2, 1'b0);
    run_ea("R2 si+d8 no sib", 8'h44, 1'b0, 3'd7, 40'h7F, 1, 0, V_ESI + 32'h7F, 3'd3, 1'b0);
  endtask

  task automatic t_direct16;
    run_ea("R3 direct d16", 8'h06, 1'b0, 3'd7, 40'hBEEF, 2, 0, 32'h0000_BEEF, 3'd3, 1'b0);
  endtask

  task automatic t_32bit;
    run_ea("R5 R4 ebx+d32", 8'h83, 1'b1, 3'd7, 40'h11223344, 4, 0, V_EBX + 32'h11223344, 3'd3, 1'b0);
    run_ea("R5 edx+d8 wrap", 8'h42, 1'b1, 3'd7, 40'h20, 1, 0, V_EDX + 32'h20, 3'd3, 1'b0);
    run_ea("R8 direct d32", 8'h05, 1'b1, 3'd7, 40'hCAFEBABE, 4, 0, 32'hCAFE_BABE, 3'd3, 1'b0);
    run_ea("R9 ebp+d8", 8'h45, 1'b1, 3'd7, 40'h00, 1, 0, V_EBP, 3'd2, 1'b0);
  endtask

  task automatic t_sib;
    run_ea("R6 eax+ecx*4+d8", 8'h44, 1'b1, 3'd7, 40'h04_88, 2, 0,
           V_EAX + (V_ECX << 2) + 32'd4, 3'd3, 1'b0);
    run_ea("R7 R9 esp no index", 8'h04, 1'b1, 3'd7, 40'hE4, 1, 0, V_ESP, 3'd2, 1'b0);
    run_ea("R8 sib base101 mod0", 8'h04, 1'b1, 3'd7, 40'h00_00_10_00_75, 5, 0,
           32'h1000 + (V_ESI << 1), 3'd3, 1'b0);
    run_ea("R9 sib ebp base mod2", 8'h84, 1'b1, 3'd7, 40'h00_00_00_10_2D, 5, 0,
           V_EBP + V_EBP + 32'h10, 3'd2, 1'b0);
  endtask

  task automatic t_override;
    run_ea("R9 override es", 8'h42, 1'b0, 3'd0, 40'hF0, 1, 0,
           (V_EBP + V_ESI - 32'd16) & 32'hFFFF, 3'd0, 1'b0);
    run_ea("R9 override gs", 8'h45, 1'b1, 3'd5, 40'h00, 1, 0, V_EBP, 3'd5, 1'b0);
  endtask

  task automatic t_regform;
    run_ea("R11 mod11 error", 8'hC1, 1'b1, 3'd7, 40'h0, 0, 0, 32'h0, 3'd3, 1'b1);
  endtask

  task automatic t_stall;
    run_ea("R10 gapped d32", 8'h83, 1'b1, 3'd7, 40'h11223344, 4, 3, V_EBX + 32'h11223344, 3'd3, 1'b0);
    run_ea("R10 gapped sib", 8'h44, 1'b1, 3'd7, 40'h04_88, 2, 2,
           V_EAX + (V_ECX << 2) + 32'd4, 3'd3, 1'b0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_16bit();
    t_direct16();
    t_32bit();
    t_sib();
    t_override();
    t_regform();
    t_stall();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule